// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a software-owned ring of transmit descriptors and reports each outcome into a second ring of status words. Software sets up both rings by writing a base address, a byte length and a current address for each. It then hands frames over by writing a count to the enqueue register. While frames are pending, the engine works through a fixed loop:

- It reads one 8-byte descriptor through a memory read port. The low 32 bits are the buffer address; the high 32 bits are the control word.
- It passes the buffer address and length to the transmitter, then waits for the transmitter's outcome.
- It writes a 4-byte status word through a memory write port. The word carries the outcome flags, the collision count and the descriptor's buffer index.

After each status write, the engine pulses a done event. Both ring pointers step forward and return to their base when they reach the programmed byte length. A descriptor marked for abort is not handed to the transmitter; only its status entry is written.

Register select codes on `reg_addr`: 0 descriptor base, 1 descriptor ring length in bytes, 2 descriptor current address, 3 status base, 4 status ring length in bytes, 5 status current address, 6 enqueue (a write adds the value; a read returns the pending count).

Top module: `txq_engine`

## Requirements
- R1: After reset, the pending count, all ring registers, `rd_req`, `tx_req`, `st_we` and `done_evt` are 0.
- R2: A write of N to code 6 adds N to the pending count, and a read of code 6 returns that count. While the count is 0, `rd_req` stays low.
- R3: While frames are pending, the engine raises `rd_req` at the descriptor current address and holds the address until `rd_gnt`. On the grant, the pending count drops by one and the descriptor address advances by 8.
- R4: For a descriptor whose control bit 15 (abort) is clear, `tx_addr` equals `rd_data[31:0]` and `tx_len` equals control bits 11:0. `tx_req` is held until `tx_done`.
- R5: After `tx_done`, the status word is laid out as follows; all other bits are 0:
  - bit 31 is 1;
  - bit 30 is `tx_ok`;
  - bit 28 is `tx_nocarrier`;
  - bit 26 is `tx_late`;
  - bit 25 is `tx_under`;
  - bit 24 is `tx_xcoll`;
  - bits 20:16 are `tx_ncoll`;
  - bits 14:0 are control bits 30:16 (the buffer index).
- R6: For a descriptor with control bit 15 set, `tx_req` is never raised. Its status word has bits 31 and 29 set and bits 14:0 equal to the buffer index; all other bits are 0.
- R7: `st_we` presents the word at the status current address and holds it until `st_ack`. The status address then advances by 4.
- R8: Both current addresses return to their base when the next offset from base would reach the ring byte length.
- R9: `done_evt` is high for exactly the one cycle after each accepted status write.
- R10: Ring registers written through the register port read back their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor byte address |
| rd_gnt | input | 1 | Descriptor data valid; accepts the request |
| rd_data | input | 64 | Descriptor: [31:0] buffer address, [63:32] control word |
| tx_req | output | 1 | Frame handed to the transmitter |
| tx_addr | output | 32 | Buffer address |
| tx_len | output | 12 | Buffer length in bytes |
| tx_done | input | 1 | Transmitter finished; outcome valid |
| tx_ok | input | 1 | Frame sent without error |
| tx_nocarrier | input | 1 | Carrier lost |
| tx_late | input | 1 | Out-of-window collision |
| tx_under | input | 1 | Underrun |
| tx_xcoll | input | 1 | Excessive collisions |
| tx_ncoll | input | 5 | Collision count |
| st_we | output | 1 | Status write request |
| st_addr | output | 32 | Status byte address |
| st_data | output | 32 | Status word |
| st_ack | input | 1 | Status write accepted |
| done_evt | output | 1 | One-cycle pulse per completed status write |

## Verification
The properties assume the following about the block's neighbours:

- The memory and transmitter assert `rd_gnt`, `tx_done` and `st_ack` only while the matching request is high.
- Software never writes a ring register while a frame is in flight.
- An enqueue write never overflows the pending counter.

The stimulus keeps to these limits in three ways. It answers each handshake only after it has observed the request. It programs the rings only while the engine is idle. It enqueues small batches of one to three frames, each drained before the next is written. Handshake delays, buffer contents and outcome flags are drawn at random, and an abort descriptor is forced at a fixed interval.

// File: rtl/txq_engine.sv
module txq_engine #(
  parameter int CW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_gnt,
  input  logic [63:0] rd_data,
  output logic        tx_req,
  output logic [31:0] tx_addr,
  output logic [11:0] tx_len,
  input  logic        tx_done,
  input  logic        tx_ok,
  input  logic        tx_nocarrier,
  input  logic        tx_late,
  input  logic        tx_under,
  input  logic        tx_xcoll,
  input  logic [4:0]  tx_ncoll,
  output logic        st_we,
  output logic [31:0] st_addr,
  output logic [31:0] st_data,
  input  logic        st_ack,
  output logic        done_evt
);
  localparam int DSTEP = 8;
  localparam int SSTEP = 4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XMIT, S_STAT} st_t;
  st_t state;

  logic [31:0] d_base, d_len, d_cur, s_base, s_len, s_cur;
  logic [31:0] buf_addr, s_word;
  logic [11:0] buf_len;
  logic [14:0] buf_idx;
  logic [CW-1:0] pend;

  wire unused_bits = &{1'b0, rd_data[63], rd_data[46:44]};

  function automatic logic [31:0] step(input logic [31:0] cur, base, len, input int inc);
    logic [31:0] off;
    off = cur - base + 32'(inc);
    return (off >= len) ? base : cur + 32'(inc);
  endfunction

  wire take = (state == S_FETCH) && rd_gnt;
  wire put  = (state == S_STAT) && st_ack;
  wire enq  = reg_we && (reg_addr == 3'd6);
  wire [CW-1:0] add = enq ? reg_wdata[CW-1:0] : '0;

  assign rd_req  = (state == S_FETCH);
  assign rd_addr = d_cur;
  assign tx_req  = (state == S_XMIT);
  assign tx_addr = buf_addr;
  assign tx_len  = buf_len;
  assign st_we   = (state == S_STAT);
  assign st_addr = s_cur;
  assign st_data = s_word;

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = d_base;
      3'd1: reg_rdata = d_len;
      3'd2: reg_rdata = d_cur;
      3'd3: reg_rdata = s_base;
      3'd4: reg_rdata = s_len;
      3'd5: reg_rdata = s_cur;
      3'd6: reg_rdata = 32'(pend);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {d_base, d_len, d_cur, s_base, s_len, s_cur} <= '0;
      buf_addr <= '0; buf_len <= '0; buf_idx <= '0; s_word <= '0;
      pend <= '0; done_evt <= 1'b0;
    end else begin
      done_evt <= put;
      pend <= pend + add - CW'(take);
      case (state)
        S_IDLE:  if (pend != '0) state <= S_FETCH;
        S_FETCH: if (rd_gnt) begin
          d_cur    <= step(d_cur, d_base, d_len, DSTEP);
          buf_addr <= rd_data[31:0];
          buf_len  <= rd_data[43:32];
          buf_idx  <= rd_data[62:48];
          if (rd_data[47]) begin
            s_word <= {3'b101, 14'd0, rd_data[62:48]};
            state  <= S_STAT;
          end else state <= S_XMIT;
        end
        S_XMIT: if (tx_done) begin
          s_word <= {1'b1, tx_ok, 1'b0, tx_nocarrier, 1'b0, tx_late, tx_under,
                     tx_xcoll, 3'd0, tx_ncoll, 1'b0, buf_idx};
          state  <= S_STAT;
        end
        S_STAT: if (st_ack) begin
          s_cur <= step(s_cur, s_base, s_len, SSTEP);
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (reg_we) begin
        case (reg_addr)
          3'd0: d_base <= reg_wdata;
          3'd1: d_len  <= reg_wdata;
          3'd2: d_cur  <= reg_wdata;
          3'd3: s_base <= reg_wdata;
          3'd4: s_len  <= reg_wdata;
          3'd5: s_cur  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          rd_req,
  input logic          rd_gnt,
  input logic [31:0]   rd_addr,
  input logic          tx_req,
  input logic          tx_done,
  input logic          st_we,
  input logic          st_ack,
  input logic [31:0]   st_addr,
  input logic [31:0]   st_data,
  input logic          done_evt,
  input logic [CW-1:0] pend
);
  p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, tx_req, st_we}));
  p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !rd_req && !tx_req && !st_we) |=> !rd_req);
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));
  p_pend_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_gnt && !(reg_we && reg_addr == 3'd6)) |=> (pend == $past(pend) - 1'b1));
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done) |=> tx_req);
  p_stat_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (st_data[31] && !st_data[27] && st_data[23:21] == 3'd0 && !st_data[15]));
  p_abort_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_data[29]) |-> (!st_data[30] && st_data[28:16] == 13'd0));
  p_stat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_ack) |=> (st_we && $stable(st_addr) && $stable(st_data)));
  p_evt_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_ack) |=> done_evt);
  p_evt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(st_we && st_ack));
endmodule

bind txq_engine txq_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr),
  .tx_req(tx_req), .tx_done(tx_done), .st_we(st_we), .st_ack(st_ack),
  .st_addr(st_addr), .st_data(st_data), .done_evt(done_evt), .pend(pend)
);

// File: tb/txq_engine_test.sv
`timescale 1ns/1ps
module txq_engine_test;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rd_req, rd_gnt = 0;
  logic [31:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic tx_req, tx_done = 0, tx_ok = 0, tx_nocarrier = 0, tx_late = 0, tx_under = 0, tx_xcoll = 0;
  logic [31:0] tx_addr;
  logic [11:0] tx_len;
  logic [4:0] tx_ncoll = 0;
  logic st_we, st_ack = 0, done_evt;
  logic [31:0] st_addr, st_data;

  int errs = 0, checks = 0;
  int unsigned seed_v;

  localparam logic [31:0] DB = 32'h1000, SB = 32'h2000;
  localparam int DENT = 4, SENT = 4, NFR = 26;

  always #2 clk = ~clk;

  txq_engine uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #0.5;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] exp_stat(input bit ab, ok, nc, lt, un, xc,
                                            input logic [4:0] ncol, input logic [14:0] idx);
    logic [31:0] w;
    w = 32'h8000_0000 | {17'd0, idx};
    if (ab) return w | 32'h2000_0000;
    if (ok) w |= 32'h4000_0000;
    if (nc) w |= 32'h1000_0000;
    if (lt) w |= 32'h0400_0000;
    if (un) w |= 32'h0200_0000;
    if (xc) w |= 32'h0100_0000;
    return w | (32'(ncol) << 16);
  endfunction

  task automatic frame(input int k, input int left);
    bit ab, ok, nc, lt, un, xc;
    logic [4:0] ncol;
    logic [14:0] idx;
    logic [11:0] len;
    logic [31:0] ba, w1, ex;
    while (!rd_req) @(negedge clk);
    chk(rd_addr == DB + 32'(8 * (k % DENT)), "R3/R8 desc addr", rd_addr, DB + 32'(8 * (k % DENT)));
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rd_req == 1'b1, "R3 req hold", 32'(rd_req), 1);
    end
    ab = (k % 5 == 3) || ($urandom % 8 == 0);
    idx = 15'($urandom); len = 12'($urandom); ba = $urandom;
    w1 = {1'b1, idx, ab, 3'b0, len};
    rd_data = {w1, ba}; rd_gnt = 1;
    @(negedge clk); rd_gnt = 0; rd_data = $urandom;
    rd_chk(3'd6, 32'(left), "R3 pending dec");
    if (!ab) begin
      chk(tx_req == 1'b1, "R4 tx req", 32'(tx_req), 1);
      chk(tx_addr == ba, "R4 tx addr", tx_addr, ba);
      chk(tx_len == len, "R4 tx len", 32'(tx_len), 32'(len));
      repeat ($urandom % 4) @(negedge clk);
      {ok, nc, lt, un, xc} = 5'($urandom); ncol = 5'($urandom);
      tx_ok = ok; tx_nocarrier = nc; tx_late = lt; tx_under = un; tx_xcoll = xc; tx_ncoll = ncol;
      tx_done = 1;
      @(negedge clk); tx_done = 0;
    end else begin
      {ok, nc, lt, un, xc} = 5'b0; ncol = 0;
      chk(tx_req == 1'b0, "R6 abort no tx", 32'(tx_req), 0);
    end
    ex = exp_stat(ab, ok, nc, lt, un, xc, ncol, idx);
    chk(st_we == 1'b1, "R7 st we", 32'(st_we), 1);
    chk(st_addr == SB + 32'(4 * (k % SENT)), "R7/R8 st addr", st_addr, SB + 32'(4 * (k % SENT)));
    chk(st_data == ex, ab ? "R6 abort status" : "R5 status", st_data, ex);
    repeat ($urandom % 3) @(negedge clk);
    st_ack = 1;
    @(negedge clk); st_ack = 0;
    chk(done_evt == 1'b1, "R9 evt high", 32'(done_evt), 1);
    @(negedge clk);
    chk(done_evt == 1'b0, "R9 evt single", 32'(done_evt), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int k;
    seed_v = $urandom(32'hC0FFEE);
    repeat (3) @(negedge clk);
    chk(!rd_req && !tx_req && !st_we && !done_evt, "R1 outputs idle",
        {rd_req, tx_req, st_we, done_evt}, 0);
    rst_n = 1;
    @(negedge clk);
    rd_chk(3'd6, 0, "R1 pending zero");
    rd_chk(3'd2, 0, "R1 desc cur zero");
    wr(3'd0, DB); wr(3'd1, 32'(8 * DENT)); wr(3'd2, DB);
    wr(3'd3, SB); wr(3'd4, 32'(4 * SENT)); wr(3'd5, SB);
    rd_chk(3'd1, 32'(8 * DENT), "R10 desc len");
    rd_chk(3'd3, SB, "R10 stat base");
    repeat (10) begin
      @(negedge clk);
      chk(rd_req == 1'b0, "R2 idle when empty", 32'(rd_req), 0);
    end
    k = 0;
    while (k < NFR) begin
      int n;
      n = 1 + int'($urandom % 3);
      wr(3'd6, 32'(n));
      rd_chk(3'd6, 32'(n), "R2 enqueue count");
      for (int j = 0; j < n; j++) begin
        frame(k, n - 1 - j);
        k++;
      end
    end
    repeat (4) @(negedge clk);
    chk(rd_req == 1'b0, "R2 idle after drain", 32'(rd_req), 0);
    rd_chk(3'd2, DB + 32'(8 * (k % DENT)), "R8 desc wrap");
    rd_chk(3'd5, SB + 32'(4 * (k % SENT)), "R8 stat wrap");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule